// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a fast copy of every word of a one-time-programmable fuse array, so that a host can read fuse contents through ordinary register reads. Each shadow word sits in a strided address window, and a small control word holds three status bits. The control word is written only through a set alias and a clear alias. Setting the reload bit starts a sequencer. The sequencer walks the fuse array from the lowest word to the highest, waits a fixed read latency on each word, and copies the result into the matching shadow word. The busy and reload bits stay high until the last word has been captured.

Each word has a read lock and a write lock, which come in as input vectors and are sampled on every access. A read of a read-locked word returns a fixed poison value. A write to a write-locked word is dropped. A shadow write that arrives while a reload runs is also dropped. Each of these cases raises a single sticky error bit. While that bit is set, the bank refuses every new shadow read, shadow write and reload request until software clears it. The fuse array sits outside the block and answers a held word address after a fixed number of cycles.

Top module: `fuse_shadow_bank`

## Requirements
- R1: After reset the control word reads 0, every shadow word reads 0, and `fuse_rd_o` is low.
- R2: Shadow word i is at address 0x400 + 0x10*i for i below NUM_WORDS. A read of any other address, apart from the control word and its aliases, returns 0. A write to any other address, including a plain write to the control word at 0x000, changes no state.
- R3: A write to an unlocked shadow word, outside a reload and with no error pending, stores the data. A later read returns that data and raises no error.
- R4: A read of a word whose `rd_lock_i` bit is set returns 0xBADABADA and sets the error bit.
- R5: A write to a word whose `wr_lock_i` bit is set leaves the word unchanged and sets the error bit.
- R6: Writing 1 to bit 2 at the set alias 0x004 starts a reload. The control word reads busy (bit 0) and reload (bit 2) as 1 from the next cycle. Both bits clear after NUM_WORDS*(FUSE_LAT+1) cycles, and every shadow word then holds its fuse value.
- R7: A shadow write during a reload sets the error bit and is dropped.
- R8: A read of an unlocked word during a reload returns that word's current shadow value, which may be stale, and raises no error.
- R9: While the error bit (bit 1) is set, a shadow read returns 0, a shadow write is dropped, and a reload request is ignored. Writing 1 to bit 1 at the clear alias 0x008 clears the error bit.
- R10: During a reload `fuse_rd_o` is high and `fuse_addr_o` counts upward from 0 in steps of one. The address advances once every FUSE_LAT+1 cycles and ends at NUM_WORDS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | High in the cycle after an accepted read |
| rd_lock_i | input | NUM_WORDS | Per-word read lock |
| wr_lock_i | input | NUM_WORDS | Per-word write lock |
| fuse_rd_o | output | 1 | Fuse read in progress |
| fuse_addr_o | output | IDX_W | Fuse word being read |
| fuse_data_i | input | 32 | Fuse word, valid FUSE_LAT cycles after the address settles |

## Verification
The assertions assume the following about the inputs:
- The fuse array never returns 0xBADABADA, so a poison value on the read port always comes from a locked read.
- The fuse array answers a held address exactly FUSE_LAT cycles later.
- The host issues at most one access per cycle.
- NUM_WORDS is one of the supported depths: 64, 128 or 256.

The bench stays within these assumptions as follows:
- Its fuse model is a FUSE_LAT-stage delay line on `fuse_addr_o`, followed by a value function whose top byte is never 0xBA.
- Its driver tasks raise a request for exactly one cycle.
- It changes lock vectors only between accesses.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CTRL_OFF   = 'h000;
  localparam int unsigned SET_OFF    = 'h004;
  localparam int unsigned CLR_OFF    = 'h008;
  localparam int unsigned WIN_BASE   = 'h400;
  localparam int unsigned STRIDE_LOG = 4;
  localparam logic [DATA_W-1:0] POISON = 32'hBADA_BADA;

  localparam int unsigned BUSY_BIT   = 0;
  localparam int unsigned ERR_BIT    = 1;
  localparam int unsigned RELOAD_BIT = 2;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTRL_RD,
    ACC_SET,
    ACC_CLR,
    ACC_WIN_RD,
    ACC_WIN_WR,
    ACC_OTHER
  } acc_e;
endpackage

// File: rtl/fsb_decode.sv
module fsb_decode
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned SLOT_W = ADDR_W - STRIDE_LOG;

  logic [ADDR_W-1:0] off;
  logic [SLOT_W-1:0] slot;
  logic              win_hit;
  logic              is_ctrl;

  always_comb begin
    off     = addr_i - ADDR_W'(WIN_BASE);
    slot    = off[ADDR_W-1:STRIDE_LOG];
    idx_o   = slot[IDX_W-1:0];
    win_hit = (addr_i >= ADDR_W'(WIN_BASE))
            && (off[STRIDE_LOG-1:0] == '0)
            && ({1'b0, slot} < (SLOT_W+1)'(NUM_WORDS));
    is_ctrl = (addr_i == ADDR_W'(CTRL_OFF)) || (addr_i == ADDR_W'(SET_OFF))
            || (addr_i == ADDR_W'(CLR_OFF));
    kind_o  = ACC_NONE;
    if (req_i) begin
      if (win_hit)                                    kind_o = we_i ? ACC_WIN_WR : ACC_WIN_RD;
      else if (!we_i && is_ctrl)                      kind_o = ACC_CTRL_RD;
      else if (we_i && addr_i == ADDR_W'(SET_OFF))    kind_o = ACC_SET;
      else if (we_i && addr_i == ADDR_W'(CLR_OFF))    kind_o = ACC_CLR;
      else                                            kind_o = ACC_OTHER;
    end
  end
endmodule

// File: rtl/fsb_reload_seq.sv
module fsb_reload_seq #(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned FUSE_LAT  = 3,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cap_o
);
  localparam int unsigned CNT_W = $clog2(FUSE_LAT + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);
  localparam logic [CNT_W-1:0] WAIT = CNT_W'(FUSE_LAT);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cnt_q  <= '0;
      end
    end else if (cnt_q == WAIT) begin
      cnt_q <= '0;
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign cap_o  = busy_q && (cnt_q == WAIT);
endmodule

// File: rtl/fsb_shadow_store.sv
module fsb_shadow_store
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0]    mem_q [NUM_WORDS];
  logic [NUM_WORDS-1:0] we_vec;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_we
    assign we_vec[g] = wr_i && (wr_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (we_vec[i]) mem_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned FUSE_LAT  = 3,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 bus_rvalid_o,
  input  logic [NUM_WORDS-1:0] rd_lock_i,
  input  logic [NUM_WORDS-1:0] wr_lock_i,
  output logic                 fuse_rd_o,
  output logic [IDX_W-1:0]     fuse_addr_o,
  input  logic [DATA_W-1:0]    fuse_data_i
);
  acc_e              kind;
  logic [IDX_W-1:0]  win_idx;
  logic              busy, cap;
  logic [IDX_W-1:0]  seq_idx;
  logic [DATA_W-1:0] shadow_rd;
  logic              err_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              set_err, clr_err, start, bus_wr_ok;
  logic              st_wr;
  logic [IDX_W-1:0]  st_idx;
  logic [DATA_W-1:0] st_data, rdata_d, status;

  fsb_decode #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .req_i  (bus_req_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .idx_o  (win_idx)
  );

  fsb_reload_seq #(.NUM_WORDS(NUM_WORDS), .FUSE_LAT(FUSE_LAT), .IDX_W(IDX_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .idx_o   (seq_idx),
    .cap_o   (cap)
  );

  fsb_shadow_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (st_wr),
    .wr_idx_i  (st_idx),
    .wr_data_i (st_data),
    .rd_idx_i  (win_idx),
    .rd_data_o (shadow_rd)
  );

  always_comb begin
    status             = '0;
    status[BUSY_BIT]   = busy;
    status[ERR_BIT]    = err_q;
    status[RELOAD_BIT] = busy;

    bus_wr_ok = (kind == ACC_WIN_WR) && !err_q && !busy && !wr_lock_i[win_idx];
    set_err   = !err_q && (((kind == ACC_WIN_RD) && rd_lock_i[win_idx])
                        || ((kind == ACC_WIN_WR) && (busy || wr_lock_i[win_idx])));
    clr_err   = (kind == ACC_CLR) && bus_wdata_i[ERR_BIT];
    start     = (kind == ACC_SET) && bus_wdata_i[RELOAD_BIT] && !err_q && !busy;

    // reload capture and bus write never coincide: bus writes are refused while busy
    st_wr   = cap || bus_wr_ok;
    st_idx  = cap ? seq_idx : win_idx;
    st_data = cap ? fuse_data_i : bus_wdata_i;

    unique case (kind)
      ACC_CTRL_RD: rdata_d = status;
      ACC_WIN_RD:  rdata_d = err_q ? '0 : (rd_lock_i[win_idx] ? POISON : shadow_rd);
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_req_i && !bus_we_i;
      if (bus_req_i && !bus_we_i) rdata_q <= rdata_d;
      if (set_err)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign fuse_rd_o    = busy;
  assign fuse_addr_o  = seq_idx;
endmodule

// File: rtl/fuse_shadow_bank_chk.sv
module fuse_shadow_bank_chk
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              err_i,
  input logic [IDX_W-1:0]  fuse_addr_i,
  input logic              rvalid_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              bus_wr_i
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  a_r10_addr_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && (fuse_addr_i != $past(fuse_addr_i)))
      |-> (fuse_addr_i == $past(fuse_addr_i) + 1'b1));

  a_r6_starts_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (fuse_addr_i == '0));

  a_r6_ends_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ($past(fuse_addr_i) == LAST));

  a_r9_no_start_in_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(err_i));

  a_r7_no_write_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i |-> (!busy_i && !err_i));

  a_r4_poison_flags_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && (rdata_i == POISON)) |-> err_i);
endmodule

bind fuse_shadow_bank fuse_shadow_bank_chk #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy),
  .err_i       (err_q),
  .fuse_addr_i (fuse_addr_o),
  .rvalid_i    (bus_rvalid_o),
  .rdata_i     (bus_rdata_o),
  .bus_wr_i    (bus_wr_ok)
);

// File: tb/fuse_shadow_bank_bench.sv
module fuse_shadow_bank_bench;
  localparam int N      = 64;
  localparam int LAT    = 3;
  localparam int AW     = 13;
  localparam int IW     = $clog2(N);
  localparam int CLK_NS = 4;
  localparam int RELOAD_CYC = N * (LAT + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [N-1:0]  rlock = '0, wlock = '0;
  logic          fuse_rd;
  logic [IW-1:0] fuse_addr;
  logic [31:0]   fuse_data;
  logic [IW-1:0] fpipe [LAT];

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_NS/2) clk = ~clk;

  fuse_shadow_bank #(.NUM_WORDS(N), .FUSE_LAT(LAT), .ADDR_W(AW)) u_fuse_shadow_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .rd_lock_i(rlock), .wr_lock_i(wlock), .fuse_rd_o(fuse_rd),
    .fuse_addr_o(fuse_addr), .fuse_data_i(fuse_data)
  );

  function automatic logic [31:0] fuse_val(int i);
    return 32'h3C00_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  function automatic logic [AW-1:0] win(int i);
    return AW'(32'h400 + i * 16);
  endfunction

  // fuse model: data follows the held address after LAT cycles
  always_ff @(posedge clk) begin
    fpipe[0] <= fuse_addr;
    for (int k = 1; k < LAT; k++) fpipe[k] <= fpipe[k-1];
  end
  assign fuse_data = fuse_val(int'(fpipe[LAT-1]));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each returned read with the head of the scoreboard
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        chk("unexpected read data", rdata, 32'hxxxx_xxxx);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    idle(3);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 fuse_rd low", 32'(fuse_rd), 0);
    rd(13'h000, 0, "R1 ctrl reset");
    rd(win(0), 0, "R1 word0 reset");
    rd(win(N-1), 0, "R1 last word reset");

    // R3 plain store
    wr(win(5), 32'h1111_2222);
    wr(win(N-1), 32'hCAFE_0063);
    rd(win(5), 32'h1111_2222, "R3 word5 readback");
    rd(win(N-1), 32'hCAFE_0063, "R3 last word readback");
    rd(13'h000, 0, "R3 no error");

    // R2 address map holes
    wr(13'h404, 32'hFFFF_FFFF);
    rd(13'h404, 0, "R2 unaligned read");
    rd(win(0), 0, "R2 unaligned write ignored");
    rd(win(N), 0, "R2 out of range read");
    wr(13'h000, 32'h4);
    rd(13'h000, 0, "R2 plain ctrl write ignored");

    // R5 write lock
    wlock[7] = 1'b1;
    wr(win(7), 32'h7777_7777);
    rd(13'h000, 32'h2, "R5 error after locked write");
    wr(13'h008, 32'h2);
    rd(win(7), 0, "R5 locked word unchanged");
    rd(13'h000, 0, "R9 error cleared");
    wlock[7] = 1'b0;

    // R4 read lock
    rlock[9] = 1'b1;
    rd(win(9), 32'hBADA_BADA, "R4 poison");
    rd(13'h000, 32'h2, "R4 error set");

    // R9 gating while error pending
    rd(win(5), 0, "R9 read gated");
    wr(win(5), 32'hDEAD_0005);
    wr(13'h004, 32'h4);
    rd(13'h000, 32'h2, "R9 reload refused");
    wr(13'h008, 32'h2);
    rd(win(5), 32'h1111_2222, "R9 gated write dropped");
    rlock[9] = 1'b0;

    // R6 / R10 reload
    wr(13'h004, 32'h4);
    chk("R10 fuse_rd high", 32'(fuse_rd), 1);
    chk("R10 addr 0", 32'(fuse_addr), 0);
    idle(LAT + 1);
    chk("R10 addr 1", 32'(fuse_addr), 1);
    idle(9 * (LAT + 1));
    chk("R10 addr 10", 32'(fuse_addr), 10);
    rd(13'h000, 32'h5, "R6 busy and reload set");
    idle(RELOAD_CYC);
    rd(13'h000, 0, "R6 busy cleared");
    chk("R10 fuse_rd low after", 32'(fuse_rd), 0);
    for (int i = 0; i < N; i++) rd(win(i), fuse_val(i), $sformatf("R6 word %0d", i));

    // R8 stale read, R7 write during reload
    wr(win(N-1), 32'h0BAD_F00D);
    wr(13'h004, 32'h4);
    rd(win(N-1), 32'h0BAD_F00D, "R8 stale read");
    rd(13'h000, 32'h5, "R8 no error");
    idle(20);
    wr(win(0), 32'h1234_5678);
    rd(13'h000, 32'h7, "R7 error during reload");
    idle(RELOAD_CYC);
    rd(13'h000, 32'h2, "R7 error kept after reload");
    wr(13'h008, 32'h2);
    rd(win(0), fuse_val(0), "R7 write dropped");
    rd(win(N-1), fuse_val(N-1), "R8 refreshed after reload");

    finish_run();
  end
endmodule